// File: doc/BRIEF.md
# Node Removal Readiness Checker

This block decides whether one node of a multi-node compute system can be taken out of service while the system keeps running. A controller places the processor counts on the inputs and pulses `start`. The processor counts are given per processor type: dedicated, nondedicated and shared-in-use. The controller also supplies the assist processor count, the spare physical processors on the nodes that stay, the memory in use and the memory those nodes hold, and one record for each I/O path of the target node. The block then works through a short sequence. First it takes the per-type sums. Then it runs two integer divisions on one shared restoring divider. Finally it scans the I/O path records one per cycle.

When the sequence ends, the block gives one of three verdicts: go as configured, go after nondedicated processors are cut back, or no go. With the verdict it reports the minimum general processor count, the minimum assist processor count, the number of processors by which the configuration must shrink, and flags that classify single-path I/O conditions. The results stay on the outputs until the next start.

Top module: `nrr_readiness`

## Requirements
- R1: After a synchronous reset, `verdict` is 0 (none), `busy` and `done` are low, and `min_gpp`, `min_assist`, `cut_count`, `io_mask` and all three I/O flags are zero.
- R2: `min_gpp` equals the sum of all dedicated counts plus the number of processor types whose shared-in-use count is nonzero.
- R3: The ratio is floor((sum dedicated + sum nondedicated) / `assist_cnt`). A ratio of zero is raised to 1. `min_assist` is `min_gpp` divided by that ratio, rounded up.
- R4: An `assist_cnt` of zero gives verdict 3 (no go), with `min_assist` and `cut_count` both 0.
- R5: Memory passes when `mem_used` <= `mem_left`. Otherwise the verdict is 3.
- R6: Path record i sits at `paths[i*5 +: 5]`. Bit 0 is online, bit 1 is alternate present, bit 2 is alternate faulty, and bits 4:3 are the alternate's node. Offline paths are skipped. An online path is flagged, in this priority order: no alternate (`io_no_alt`), then faulty alternate (`io_alt_bad`), then alternate on `target_node` (`io_alt_local`). Bit i of `io_mask` marks a flagged path.
- R7: Any flagged path gives verdict 3.
- R8: Define need = sum dedicated + sum nondedicated + `assist_cnt`. When need <= `spare` and memory and I/O pass, the verdict is 1 (go) and `cut_count` is 0.
- R9: When need > `spare` but `min_gpp` + `min_assist` <= `spare`, and memory and I/O pass, the verdict is 2 (go with reassignment) and `cut_count` = need - `spare`.
- R10: When `min_gpp` + `min_assist` > `spare` and `assist_cnt` is nonzero, the verdict is 3 and `cut_count` = `min_gpp` + `min_assist` - `spare`.
- R11: A `start` seen while idle raises `busy` on the next cycle. `done` is a single-cycle pulse with `busy` low. The result outputs change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation (accepted when idle) |
| ded_cnt | input | N_TYPES*CNT_W | Dedicated processors per type |
| nd_cnt | input | N_TYPES*CNT_W | Nondedicated processors per type |
| shr_cnt | input | N_TYPES*CNT_W | Shared processors in use per type |
| assist_cnt | input | CNT_W | Current assist processor count |
| spare | input | SUM_W+1 | Spare physical processors on remaining nodes |
| mem_used | input | MEM_W | Memory in use, reserved area included |
| mem_left | input | MEM_W | Physical memory on remaining nodes |
| target_node | input | NODE_W | Node to be removed |
| paths | input | N_PATHS*(3+NODE_W) | I/O path records of the target node |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| verdict | output | 2 | 0 none, 1 go, 2 go with reassignment, 3 no go |
| min_gpp | output | SUM_W | Minimum general processor count |
| min_assist | output | SUM_W | Minimum assist processor count |
| cut_count | output | SUM_W+1 | Required processor reduction or shortfall |
| io_no_alt | output | 1 | Some online path lacks an alternate |
| io_alt_bad | output | 1 | Some online path has a faulty alternate |
| io_alt_local | output | 1 | Some alternate lands on the target node |
| io_mask | output | N_PATHS | Per-path single-path flag |

## Verification
The checks assume that every data input stays constant from `start` until `done`. Several assertions relate the verdict at `done` directly to `assist_cnt`, `mem_used` and `mem_left`, so this assumption matters. The bench sets all inputs at a falling edge before it pulses `start`, and it changes none of them until it has sampled the completion pulse. It gives no second `start` during a run, and it only ever supplies path records that follow the documented field layout.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_GO     = 2'd1,
    VERD_SHRINK = 2'd2,
    VERD_HALT   = 2'd3
  } verdict_t;

  localparam int REC_ONLINE = 0;
  localparam int REC_HAS_ALT = 1;
  localparam int REC_ALT_BAD = 2;
  localparam int REC_NODE_LSB = 3;
endpackage

// File: rtl/nrr_tally.sv
module nrr_tally #(
  parameter int N_TYPES = 5,
  parameter int CNT_W = 6,
  parameter int SUM_W = 10
) (
  input  logic [N_TYPES*CNT_W-1:0] ded_cnt,
  input  logic [N_TYPES*CNT_W-1:0] nd_cnt,
  input  logic [N_TYPES*CNT_W-1:0] shr_cnt,
  output logic [SUM_W-1:0]         ded_sum,
  output logic [SUM_W-1:0]         nd_sum,
  output logic [SUM_W-1:0]         live_types
);
  logic [N_TYPES-1:0] live;

  // a type counts toward the floor when any of its shared processors run
  for (genvar t = 0; t < N_TYPES; t++) begin : g_live
    assign live[t] = |shr_cnt[t*CNT_W +: CNT_W];
  end

  always_comb begin
    ded_sum = '0;
    nd_sum = '0;
    live_types = '0;
    for (int t = 0; t < N_TYPES; t++) begin
      ded_sum = ded_sum + SUM_W'(ded_cnt[t*CNT_W +: CNT_W]);
      nd_sum = nd_sum + SUM_W'(nd_cnt[t*CNT_W +: CNT_W]);
      live_types = live_types + SUM_W'(live[t]);
    end
  end
endmodule

// File: rtl/nrr_divider.sv
module nrr_divider #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    acc;
  logic [W-1:0]  q;
  logic [W-1:0]  dvs;
  logic [CW-1:0] left;
  logic          run;
  logic [W:0]    shifted;
  logic          fits;

  always_comb begin
    shifted = {acc[W-1:0], q[W-1]};
    fits = shifted >= {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      q <= '0;
      dvs <= '0;
      left <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc <= '0;
        q <= dividend;
        dvs <= divisor;
        left <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        acc <= fits ? shifted - {1'b0, dvs} : shifted;
        q <= {q[W-2:0], fits};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = q;
  assign rem = acc[W-1:0];
endmodule

// File: rtl/nrr_path_scan.sv
module nrr_path_scan
  import nrr_pkg::*;
#(
  parameter int N_PATHS = 8,
  parameter int NODE_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          go,
  input  logic [NODE_W-1:0]             target_node,
  input  logic [N_PATHS*(3+NODE_W)-1:0] paths,
  output logic                          ready,
  output logic [N_PATHS-1:0]            mask,
  output logic                          no_alt,
  output logic                          alt_bad,
  output logic                          alt_local
);
  localparam int REC_W = 3 + NODE_W;
  localparam int IDX_W = (N_PATHS > 1) ? $clog2(N_PATHS) : 1;

  logic [IDX_W-1:0] idx;
  logic             walking;
  logic [REC_W-1:0] rec;
  logic             hit_none, hit_bad, hit_local;

  always_comb begin
    rec = paths[idx*REC_W +: REC_W];
    hit_none = 1'b0;
    hit_bad = 1'b0;
    hit_local = 1'b0;
    if (rec[REC_ONLINE]) begin
      if (!rec[REC_HAS_ALT]) hit_none = 1'b1;
      else if (rec[REC_ALT_BAD]) hit_bad = 1'b1;
      else if (rec[REC_NODE_LSB +: NODE_W] == target_node) hit_local = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      walking <= 1'b0;
      ready <= 1'b0;
      mask <= '0;
      no_alt <= 1'b0;
      alt_bad <= 1'b0;
      alt_local <= 1'b0;
    end else if (go) begin
      idx <= '0;
      walking <= 1'b1;
      ready <= 1'b0;
      mask <= '0;
      no_alt <= 1'b0;
      alt_bad <= 1'b0;
      alt_local <= 1'b0;
    end else if (walking) begin
      mask[idx] <= hit_none | hit_bad | hit_local;
      no_alt <= no_alt | hit_none;
      alt_bad <= alt_bad | hit_bad;
      alt_local <= alt_local | hit_local;
      if (idx == IDX_W'(N_PATHS - 1)) begin
        walking <= 1'b0;
        ready <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrr_readiness.sv
module nrr_readiness
  import nrr_pkg::*;
#(
  parameter int N_TYPES = 5,
  parameter int CNT_W = 6,
  parameter int N_PATHS = 8,
  parameter int NODE_W = 2,
  parameter int MEM_W = 16,
  localparam int SUM_W = CNT_W + $clog2(N_TYPES) + 2,
  localparam int SP_W = SUM_W + 1,
  localparam int REC_W = 3 + NODE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [N_TYPES*CNT_W-1:0]   ded_cnt,
  input  logic [N_TYPES*CNT_W-1:0]   nd_cnt,
  input  logic [N_TYPES*CNT_W-1:0]   shr_cnt,
  input  logic [CNT_W-1:0]           assist_cnt,
  input  logic [SP_W-1:0]            spare,
  input  logic [MEM_W-1:0]           mem_used,
  input  logic [MEM_W-1:0]           mem_left,
  input  logic [NODE_W-1:0]          target_node,
  input  logic [N_PATHS*REC_W-1:0]   paths,
  output logic                       busy,
  output logic                       done,
  output logic [1:0]                 verdict,
  output logic [SUM_W-1:0]           min_gpp,
  output logic [SUM_W-1:0]           min_assist,
  output logic [SP_W-1:0]            cut_count,
  output logic                       io_no_alt,
  output logic                       io_alt_bad,
  output logic                       io_alt_local,
  output logic [N_PATHS-1:0]         io_mask
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SUM, ST_RATIO_GO, ST_RATIO_WAIT, ST_MIN_GO, ST_MIN_WAIT, ST_END
  } step_t;

  step_t state;

  logic [SUM_W-1:0] ded_sum, nd_sum, live_types;
  logic [SUM_W-1:0] all_q, gpp_q, ratio_q, minas_q;
  logic [CNT_W-1:0] assist_q;
  logic [SP_W-1:0]  spare_q;
  logic             mem_ok_q, zero_q;

  logic             div_go, div_fin;
  logic [SUM_W-1:0] div_num, div_den, div_quo, div_rem;

  logic             scan_go, scan_ready;
  logic [N_PATHS-1:0] scan_mask;
  logic             scan_none, scan_bad, scan_local;

  logic [SP_W-1:0]  need, floor_need;
  logic             fit_full, fit_floor, io_fail;
  verdict_t         verd_c;
  logic [SP_W-1:0]  cut_c;

  nrr_tally #(.N_TYPES(N_TYPES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_tally (
    .ded_cnt(ded_cnt), .nd_cnt(nd_cnt), .shr_cnt(shr_cnt),
    .ded_sum(ded_sum), .nd_sum(nd_sum), .live_types(live_types)
  );

  // one divider serves both the ratio and the rounded-up floor division
  assign div_go = (state == ST_RATIO_GO) || (state == ST_MIN_GO);
  assign div_num = (state == ST_RATIO_GO) ? all_q : gpp_q;
  assign div_den = (state == ST_RATIO_GO) ? SUM_W'(assist_q) : ratio_q;

  nrr_divider #(.W(SUM_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_num), .divisor(div_den),
    .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  assign scan_go = (state == ST_IDLE) && start;

  nrr_path_scan #(.N_PATHS(N_PATHS), .NODE_W(NODE_W)) u_scan (
    .clk(clk), .rst(rst), .go(scan_go), .target_node(target_node), .paths(paths),
    .ready(scan_ready), .mask(scan_mask), .no_alt(scan_none),
    .alt_bad(scan_bad), .alt_local(scan_local)
  );

  always_comb begin
    need = SP_W'(all_q) + SP_W'(assist_q);
    floor_need = SP_W'(gpp_q) + SP_W'(minas_q);
    fit_full = need <= spare_q;
    fit_floor = floor_need <= spare_q;
    io_fail = scan_none | scan_bad | scan_local;
    if (zero_q) begin
      verd_c = VERD_HALT;
      cut_c = '0;
    end else begin
      if (fit_full) cut_c = '0;
      else if (fit_floor) cut_c = need - spare_q;
      else cut_c = floor_need - spare_q;
      if (!mem_ok_q || io_fail) verd_c = VERD_HALT;
      else if (fit_full) verd_c = VERD_GO;
      else if (fit_floor) verd_c = VERD_SHRINK;
      else verd_c = VERD_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
      verdict <= VERD_NONE;
      min_gpp <= '0;
      min_assist <= '0;
      cut_count <= '0;
      io_no_alt <= 1'b0;
      io_alt_bad <= 1'b0;
      io_alt_local <= 1'b0;
      io_mask <= '0;
      all_q <= '0;
      gpp_q <= '0;
      ratio_q <= '0;
      minas_q <= '0;
      assist_q <= '0;
      spare_q <= '0;
      mem_ok_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SUM;
            busy <= 1'b1;
          end
        end
        ST_SUM: begin
          all_q <= ded_sum + nd_sum;
          gpp_q <= ded_sum + live_types;
          assist_q <= assist_cnt;
          spare_q <= spare;
          mem_ok_q <= mem_used <= mem_left;
          zero_q <= assist_cnt == '0;
          minas_q <= '0;
          state <= (assist_cnt == '0) ? ST_END : ST_RATIO_GO;
        end
        ST_RATIO_GO: state <= ST_RATIO_WAIT;
        ST_RATIO_WAIT: begin
          if (div_fin) begin
            ratio_q <= (div_quo == '0) ? SUM_W'(1) : div_quo;
            state <= ST_MIN_GO;
          end
        end
        ST_MIN_GO: state <= ST_MIN_WAIT;
        ST_MIN_WAIT: begin
          if (div_fin) begin
            minas_q <= div_quo + SUM_W'(div_rem != '0);
            state <= ST_END;
          end
        end
        ST_END: begin
          if (scan_ready) begin
            verdict <= verd_c;
            min_gpp <= gpp_q;
            min_assist <= minas_q;
            cut_count <= cut_c;
            io_no_alt <= scan_none;
            io_alt_bad <= scan_bad;
            io_alt_local <= scan_local;
            io_mask <= scan_mask;
            done <= 1'b1;
            busy <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrr_readiness_props.sv
module nrr_readiness_props #(
  parameter int CNT_W = 6,
  parameter int N_PATHS = 8,
  parameter int MEM_W = 16,
  parameter int SUM_W = 11,
  parameter int SP_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [CNT_W-1:0]   assist_cnt,
  input logic [MEM_W-1:0]   mem_used,
  input logic [MEM_W-1:0]   mem_left,
  input logic               busy,
  input logic               done,
  input logic [1:0]         verdict,
  input logic [SUM_W-1:0]   min_gpp,
  input logic [SUM_W-1:0]   min_assist,
  input logic [SP_W-1:0]    cut_count,
  input logic               io_no_alt,
  input logic               io_alt_bad,
  input logic               io_alt_local,
  input logic [N_PATHS-1:0] io_mask
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r11_start_busy: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  a_r11_verdict_hold: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(verdict));
  a_r4_zero_assist: assert property (@(posedge clk) disable iff (rst)
    (done && assist_cnt == '0) |-> (verdict == 2'd3 && min_assist == '0 && cut_count == '0));
  a_r5_memory_short: assert property (@(posedge clk) disable iff (rst)
    (done && mem_used > mem_left) |-> verdict == 2'd3);
  a_r7_io_blocks: assert property (@(posedge clk) disable iff (rst)
    (done && io_mask != '0) |-> verdict == 2'd3);
  a_r6_flags_match_mask: assert property (@(posedge clk) disable iff (rst)
    done |-> ((io_mask != '0) == (io_no_alt || io_alt_bad || io_alt_local)));
  a_r8_go_no_cut: assert property (@(posedge clk) disable iff (rst)
    (done && verdict == 2'd1) |-> cut_count == '0);
  a_r9_shrink_cut: assert property (@(posedge clk) disable iff (rst)
    (done && verdict == 2'd2) |-> cut_count != '0);
  a_r3_assist_floor: assert property (@(posedge clk) disable iff (rst)
    (done && assist_cnt != '0 && min_gpp != '0) |-> min_assist != '0);
  a_r2_result_set: assert property (@(posedge clk) disable iff (rst)
    done |-> verdict != 2'd0);
endmodule

bind nrr_readiness nrr_readiness_props #(
  .CNT_W(CNT_W), .N_PATHS(N_PATHS), .MEM_W(MEM_W), .SUM_W(SUM_W), .SP_W(SP_W)
) u_props (
  .clk(clk), .rst(rst), .start(start), .assist_cnt(assist_cnt),
  .mem_used(mem_used), .mem_left(mem_left), .busy(busy), .done(done),
  .verdict(verdict), .min_gpp(min_gpp), .min_assist(min_assist),
  .cut_count(cut_count), .io_no_alt(io_no_alt), .io_alt_bad(io_alt_bad),
  .io_alt_local(io_alt_local), .io_mask(io_mask)
);

// File: tb/nrr_readiness_test.sv
module nrr_readiness_test;
  localparam int NT = 5;
  localparam int CW = 6;
  localparam int NP = 8;
  localparam int SUMW = CW + $clog2(NT) + 2;
  localparam int SPW = SUMW + 1;

  typedef struct packed {
    logic [NT*CW-1:0] ded;
    logic [NT*CW-1:0] nd;
    logic [NT*CW-1:0] shr;
    logic [CW-1:0]    asp;
    logic [SPW-1:0]   spr;
    logic [15:0]      mu;
    logic [15:0]      ml;
    logic [NP*5-1:0]  pth;
  } vec_t;

  localparam logic [NP*5-1:0] CLEAN = {NP{5'b01011}};
  localparam logic [NT*CW-1:0] X_DED = {6'd0, 6'd0, 6'd1, 6'd1, 6'd2};
  localparam logic [NT*CW-1:0] X_ND = {6'd0, 6'd2, 6'd2, 6'd2, 6'd6};
  localparam logic [NT*CW-1:0] X_SHR = {6'd0, 6'd1, 6'd2, 6'd0, 6'd3};
  localparam int NV = 7;
  localparam vec_t TABLE [NV] = '{
    '{X_DED, X_ND, X_SHR, 6'd4, 12'd20, 16'd500, 16'd900, CLEAN},
    '{X_DED, X_ND, X_SHR, 6'd4, 12'd12, 16'd500, 16'd900, CLEAN},
    '{X_DED, X_ND, X_SHR, 6'd4, 12'd6, 16'd500, 16'd900, CLEAN},
    '{30'd1, 30'd64, 30'd64, 6'd4, 12'd20, 16'd10, 16'd10, CLEAN},
    '{X_DED, X_ND, X_SHR, 6'd4, 12'd20, 16'd1000, 16'd1000, CLEAN},
    '{X_DED, X_ND, X_SHR, 6'd4, 12'd20, 16'd1001, 16'd1000, CLEAN},
    '{30'd3, 30'd5, 30'd1, 6'd2, 12'd5, 16'd1, 16'd2, CLEAN}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NT*CW-1:0] ded_cnt = '0, nd_cnt = '0, shr_cnt = '0;
  logic [CW-1:0] assist_cnt = '0;
  logic [SPW-1:0] spare = '0;
  logic [15:0] mem_used = '0, mem_left = '0;
  logic [1:0] target_node = '0;
  logic [NP*5-1:0] paths = '0;
  logic busy, done;
  logic [1:0] verdict;
  logic [SUMW-1:0] min_gpp, min_assist;
  logic [SPW-1:0] cut_count;
  logic io_no_alt, io_alt_bad, io_alt_local;
  logic [NP-1:0] io_mask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  nrr_readiness uut (
    .clk(clk), .rst(rst), .start(start), .ded_cnt(ded_cnt), .nd_cnt(nd_cnt),
    .shr_cnt(shr_cnt), .assist_cnt(assist_cnt), .spare(spare),
    .mem_used(mem_used), .mem_left(mem_left), .target_node(target_node),
    .paths(paths), .busy(busy), .done(done), .verdict(verdict),
    .min_gpp(min_gpp), .min_assist(min_assist), .cut_count(cut_count),
    .io_no_alt(io_no_alt), .io_alt_bad(io_alt_bad), .io_alt_local(io_alt_local),
    .io_mask(io_mask)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input vec_t v, output int res, output int gpp,
                       output int mas, output int cut, output int msk);
    int ds, ns, lv, ratio, need, fl;
    bit io;
    ds = 0; ns = 0; lv = 0; msk = 0;
    for (int t = 0; t < NT; t++) begin
      ds += int'(v.ded[t*CW +: CW]);
      ns += int'(v.nd[t*CW +: CW]);
      if (v.shr[t*CW +: CW] != 0) lv++;
    end
    for (int p = 0; p < NP; p++) begin
      logic [4:0] r;
      r = v.pth[p*5 +: 5];
      if (r[0] && (!r[1] || r[2] || r[4:3] == target_node)) msk |= (1 << p);
    end
    io = msk != 0;
    gpp = ds + lv;
    need = ds + ns + int'(v.asp);
    if (v.asp == 0) begin
      mas = 0; cut = 0; res = 3;
    end else begin
      ratio = (ds + ns) / int'(v.asp);
      if (ratio == 0) ratio = 1;
      mas = (gpp + ratio - 1) / ratio;
      fl = gpp + mas;
      if (need <= int'(v.spr)) cut = 0;
      else if (fl <= int'(v.spr)) cut = need - int'(v.spr);
      else cut = fl - int'(v.spr);
      if (v.mu > v.ml || io) res = 3;
      else if (need <= int'(v.spr)) res = 1;
      else if (fl <= int'(v.spr)) res = 2;
      else res = 3;
    end
  endtask

  task automatic run(input vec_t v, output bit ok);
    @(negedge clk);
    ded_cnt = v.ded; nd_cnt = v.nd; shr_cnt = v.shr; assist_cnt = v.asp;
    spare = v.spr; mem_used = v.mu; mem_left = v.ml; paths = v.pth;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after start", int'(busy), 1);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    check("R11 done pulse seen", int'(ok), 1);
    if (ok) check("R11 busy low at done", int'(busy), 0);
  endtask

  task automatic run_and_compare(input vec_t v, input string tag);
    int res, gpp, mas, cut, msk;
    bit ok;
    model(v, res, gpp, mas, cut, msk);
    run(v, ok);
    check({tag, " R2 min_gpp"}, int'(min_gpp), gpp);
    check({tag, " R3 min_assist"}, int'(min_assist), mas);
    check({tag, " R8/R9/R10 verdict"}, int'(verdict), res);
    check({tag, " R9/R10 cut_count"}, int'(cut_count), cut);
    check({tag, " R6 io_mask"}, int'(io_mask), msk);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    vec_t v;
    bit ok;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 verdict", int'(verdict), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 min_gpp", int'(min_gpp), 0);
    check("R1 cut_count", int'(cut_count), 0);
    check("R1 io_mask", int'(io_mask), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_and_compare(TABLE[k], $sformatf("vec%0d", k));

    // R2 R3: worked example with literal expectations
    run(TABLE[0], ok);
    check("R2 example min_gpp", int'(min_gpp), 7);
    check("R3 example min_assist", int'(min_assist), 2);
    check("R8 example go", int'(verdict), 1);
    run(TABLE[1], ok);
    check("R9 example reassign", int'(verdict), 2);
    check("R9 example cut", int'(cut_count), 8);
    run(TABLE[2], ok);
    check("R10 example no go", int'(verdict), 3);
    check("R10 example shortfall", int'(cut_count), 3);
    run(TABLE[5], ok);
    check("R5 memory over", int'(verdict), 3);
    check("R11 held after done", int'(verdict), 3);
    @(negedge clk);
    check("R11 done single cycle", int'(done), 0);

    // R4: zero assist processors
    v = TABLE[0];
    v.asp = '0;
    run(v, ok);
    check("R4 verdict", int'(verdict), 3);
    check("R4 min_assist", int'(min_assist), 0);
    check("R4 cut_count", int'(cut_count), 0);

    // R6 R7: path classes; path0 offline without alternate is skipped
    v = TABLE[0];
    v.pth = CLEAN;
    v.pth[0*5 +: 5] = 5'b00000;
    v.pth[1*5 +: 5] = 5'b00001;
    v.pth[2*5 +: 5] = 5'b01111;
    v.pth[3*5 +: 5] = 5'b00011;
    run(v, ok);
    check("R6 mask", int'(io_mask), 'b00001110);
    check("R6 no_alt", int'(io_no_alt), 1);
    check("R6 alt_bad", int'(io_alt_bad), 1);
    check("R6 alt_local", int'(io_alt_local), 1);
    check("R7 verdict", int'(verdict), 3);

    // R6: only a faulty alternate; priority keeps other flags clear
    v.pth = CLEAN;
    v.pth[5*5 +: 5] = 5'b00111;
    run(v, ok);
    check("R6 single bad mask", int'(io_mask), 'b00100000);
    check("R6 single bad no_alt clear", int'(io_no_alt), 0);
    check("R6 single bad local clear", int'(io_alt_local), 0);
    check("R6 single bad flag", int'(io_alt_bad), 1);

    // R1: reset after activity clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 verdict after reset", int'(verdict), 0);
    check("R1 io_mask after reset", int'(io_mask), 0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule